// File: doc/BRIEF.md
# Quarter-Step Resolution PWM Generator

This block drives one pulse-width modulated output. Its period timer is an 8-bit counter that advances once every four clocks. A 2-bit phase counter below it tracks the clock within each group of four. Together the two form a 10-bit position inside the period. That position is compared against a 10-bit duty value, so the high time can be set to the single clock while the period is set in steps of four clocks.

Software reaches the block through a simple write port with four register slots: period, duty upper byte, duty fraction and control. Period and duty writes go into holding registers. The running timer picks them up only when a new period begins, so a cycle is never cut short or stretched. A sticky end-of-period flag tells software when a fresh period has started and new values can be written.

Top module: `qpwm_gen`

## Requirements
- R1: After a synchronous reset, `pwm_out` and `irq_flag` are 0, the generator is stopped, and all holding and active registers are zero.
- R2: While running, one period lasts (P + 1) × 4 clocks, where P is the 8-bit period register.
- R3: The output stays high for exactly D clocks of each period, where D = duty_upper × 4 + duty_fraction. This holds when D is below the period length.
- R4: Register slot 0 is the period, and slot 1 is the duty upper byte. Slot 2 holds the duty fraction in data bits 7:6, and its bits 5:0 are ignored. Slot 3 is control: bit 0 starts (1) or stops (0) the generator, and a 1 in bit 1 clears the flag.
- R5: The output rises only at position 0 of a period. It falls in the first clock whose position {timer, phase} equals D.
- R6: With D = 0 the output stays low for the whole period. With D at or above (P + 1) × 4 it stays high for the whole period.
- R7: Period and duty writes made during a period do not change that period. They take effect from the next period start. While the generator is stopped, the holding values load continuously, so the first period after a start uses the values present at the start write.
- R8: At the last clock of each period the flag is set. It stays set until a control write with bit 1 set clears it. If a clear and a period end fall on the same edge, the flag ends up set.
- R9: Writing 0 to control bit 0 forces the output low from the next clock and returns the timer and phase to 0. The flag keeps its value.
- R10: P = FFh gives a 1024-clock period with all 10 duty bits usable. P = 3Fh gives a 256-clock period, where an 8-bit value v written as upper = v >> 2 and fraction = (v & 3) << 6 produces v high clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every position step is one clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one register slot |
| wr_addr | input | 2 | Register slot selector |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | Registered PWM waveform |
| irq_flag | output | 1 | Sticky end-of-period flag |

## Verification
The hardest case to reach is a flag clear that lands on the same edge as a period end, where the set must win. The stimulus sets the period to its minimum of four clocks. It locks onto position 0 by watching the flag rise, counts three clocks, and then issues the clear so that it lands exactly on the wrap edge. A second hard case is a duty write in the middle of a period. The bench waits for a period start, rewrites the duty one clock later, and confirms that the running period keeps its old high time while the next period shows the new one.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  typedef enum logic [1:0] {
    SLOT_PERIOD  = 2'd0,
    SLOT_DUTY_HI = 2'd1,
    SLOT_DUTY_FR = 2'd2,
    SLOT_CTRL    = 2'd3
  } slot_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;
endpackage

// File: rtl/qpwm_regs.sv
module qpwm_regs
  import qpwm_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PH_W  = 2,
  localparam int DUTY_W = CNT_W + PH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              wrap,
  output logic [CNT_W-1:0]  per_hold,
  output logic [DUTY_W-1:0] duty_hold,
  output logic              run_q,
  output logic              run_nxt,
  output logic              irq_q
);
  logic [CNT_W-1:0] duty_hi_q;
  logic [PH_W-1:0]  duty_fr_q;
  logic             ctrl_wr;

  assign ctrl_wr   = wr_en && (slot_e'(wr_addr) == SLOT_CTRL);
  assign run_nxt   = ctrl_wr ? wr_data[CTRL_RUN_BIT] : run_q;
  assign duty_hold = {duty_hi_q, duty_fr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      per_hold  <= '0;
      duty_hi_q <= '0;
      duty_fr_q <= '0;
    end else if (wr_en) begin
      case (slot_e'(wr_addr))
        SLOT_PERIOD:  per_hold  <= wr_data;
        SLOT_DUTY_HI: duty_hi_q <= wr_data;
        SLOT_DUTY_FR: duty_fr_q <= wr_data[CNT_W-1 -: PH_W];
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      run_q <= run_nxt;
      if (wrap)
        irq_q <= 1'b1;
      else if (ctrl_wr && wr_data[CTRL_CLR_BIT])
        irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/qpwm_timebase.sv
module qpwm_timebase #(
  parameter int CNT_W = 8,
  parameter int PH_W  = 2,
  localparam int DUTY_W = CNT_W + PH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_q,
  input  logic [CNT_W-1:0]  per_hold,
  input  logic [DUTY_W-1:0] duty_hold,
  output logic [CNT_W-1:0]  tmr_q,
  output logic [PH_W-1:0]   ph_q,
  output logic [CNT_W-1:0]  per_act,
  output logic [DUTY_W-1:0] duty_act,
  output logic              wrap,
  output logic [DUTY_W-1:0] pos_nxt,
  output logic [DUTY_W-1:0] duty_nxt
);
  localparam logic [PH_W-1:0] PH_LAST = '1;

  logic [CNT_W-1:0] tmr_n;
  logic [PH_W-1:0]  ph_n;
  logic [CNT_W-1:0] per_n;

  always_comb begin
    wrap = run_q && (ph_q == PH_LAST) && (tmr_q == per_act);
    if (!run_q || wrap) begin
      tmr_n    = '0;
      ph_n     = '0;
      per_n    = per_hold;
      duty_nxt = duty_hold;
    end else begin
      per_n    = per_act;
      duty_nxt = duty_act;
      if (ph_q == PH_LAST) begin
        ph_n  = '0;
        tmr_n = tmr_q + 1'b1;
      end else begin
        ph_n  = ph_q + 1'b1;
        tmr_n = tmr_q;
      end
    end
    pos_nxt = {tmr_n, ph_n};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q    <= '0;
      ph_q     <= '0;
      per_act  <= '0;
      duty_act <= '0;
    end else begin
      tmr_q    <= tmr_n;
      ph_q     <= ph_n;
      per_act  <= per_n;
      duty_act <= duty_nxt;
    end
  end
endmodule

// File: rtl/qpwm_compare.sv
module qpwm_compare #(
  parameter int DUTY_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_nxt,
  input  logic [DUTY_W-1:0] pos_nxt,
  input  logic [DUTY_W-1:0] duty_nxt,
  output logic              pwm_q
);
  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= run_nxt && (pos_nxt < duty_nxt);
  end
endmodule

// File: rtl/qpwm_gen.sv
module qpwm_gen #(
  parameter int CNT_W = 8,
  parameter int PH_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             irq_flag
);
  localparam int DUTY_W = CNT_W + PH_W;

  logic [CNT_W-1:0]  per_hold, per_act, tmr_q;
  logic [DUTY_W-1:0] duty_hold, duty_act, pos_nxt, duty_nxt;
  logic [PH_W-1:0]   ph_q;
  logic              run_q, run_nxt, wrap;

  qpwm_regs #(.CNT_W(CNT_W), .PH_W(PH_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wrap(wrap), .per_hold(per_hold), .duty_hold(duty_hold),
    .run_q(run_q), .run_nxt(run_nxt), .irq_q(irq_flag)
  );

  qpwm_timebase #(.CNT_W(CNT_W), .PH_W(PH_W)) u_tb (
    .clk(clk), .rst(rst), .run_q(run_q), .per_hold(per_hold), .duty_hold(duty_hold),
    .tmr_q(tmr_q), .ph_q(ph_q), .per_act(per_act), .duty_act(duty_act),
    .wrap(wrap), .pos_nxt(pos_nxt), .duty_nxt(duty_nxt)
  );

  qpwm_compare #(.DUTY_W(DUTY_W)) u_cmp (
    .clk(clk), .rst(rst), .run_nxt(run_nxt), .pos_nxt(pos_nxt),
    .duty_nxt(duty_nxt), .pwm_q(pwm_out)
  );
endmodule

// File: rtl/qpwm_chk.sv
module qpwm_chk #(
  parameter int CNT_W = 8,
  parameter int PH_W  = 2,
  localparam int DUTY_W = CNT_W + PH_W
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [CNT_W-1:0]  wr_data,
  input logic              run_q,
  input logic              wrap,
  input logic [CNT_W-1:0]  tmr_q,
  input logic [PH_W-1:0]   ph_q,
  input logic [CNT_W-1:0]  per_act,
  input logic [DUTY_W-1:0] duty_act,
  input logic              pwm_out,
  input logic              irq_flag
);
  logic [DUTY_W:0] cyc;
  logic [DUTY_W:0] span_last;
  logic            clr_req;

  assign span_last = {1'b0, per_act, {PH_W{1'b1}}};
  assign clr_req   = wr_en && (wr_addr == 2'd3) && wr_data[1];

  always_ff @(posedge clk) begin
    if (rst || !run_q || wrap) cyc <= '0;
    else                       cyc <= cyc + 1'b1;
  end

  // R2: a period ends after exactly (P+1)*4 clocks
  p_period_len_r2: assert property (@(posedge clk) disable iff (rst)
    wrap |-> cyc == span_last);

  // R2: timer never passes the active period value
  p_tmr_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run_q |-> tmr_q <= per_act);

  // R5: rising edges only at position 0
  p_rise_at_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> (tmr_q == '0 && ph_q == '0));

  // R6: zero duty keeps output low
  p_zero_duty_low_r6: assert property (@(posedge clk) disable iff (rst)
    (duty_act == '0) |-> !pwm_out);

  // R7: active values change only at a period start or while stopped
  p_active_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (run_q && !wrap) |=> ($stable(duty_act) && $stable(per_act)));

  // R8: period end sets the flag, even with a clear on the same edge
  p_flag_set_r8: assert property (@(posedge clk) disable iff (rst)
    wrap |=> irq_flag);

  // R8: flag holds without a clear request
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !clr_req) |=> irq_flag);

  // R9: output is low whenever the generator is stopped
  p_out_needs_run_r9: assert property (@(posedge clk) disable iff (rst)
    pwm_out |-> run_q);
endmodule

bind qpwm_gen qpwm_chk #(.CNT_W(CNT_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .run_q(run_q), .wrap(wrap), .tmr_q(tmr_q), .ph_q(ph_q), .per_act(per_act),
  .duty_act(duty_act), .pwm_out(pwm_out), .irq_flag(irq_flag)
);

// File: tb/qpwm_gen_tb.sv
`timescale 1ns/1ps
module qpwm_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       pwm_out, irq_flag;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  qpwm_gen u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
                  .wr_data(wr_data), .pwm_out(pwm_out), .irq_flag(irq_flag));

  // Behavioural reference model
  int m_run, m_tmr, m_ph, m_per, m_duty, m_pwm, m_irq, s_per, s_duty;
  always @(posedge clk) begin
    if (rst) begin
      m_run = 0; m_tmr = 0; m_ph = 0; m_per = 0; m_duty = 0;
      m_pwm = 0; m_irq = 0; s_per = 0; s_duty = 0;
    end else begin
      int wrp, cw, nrun;
      wrp  = (m_run != 0) && m_ph == 3 && m_tmr == m_per;
      cw   = wr_en && wr_addr == 2'd3;
      nrun = cw ? int'(wr_data[0]) : m_run;
      if (m_run == 0 || wrp) begin
        m_tmr = 0; m_ph = 0; m_per = s_per; m_duty = s_duty;
      end else if (m_ph == 3) begin
        m_ph = 0; m_tmr = m_tmr + 1;
      end else m_ph = m_ph + 1;
      if (wrp) m_irq = 1;
      else if (cw && wr_data[1]) m_irq = 0;
      if (wr_en) begin
        if (wr_addr == 2'd0) s_per = int'(wr_data);
        else if (wr_addr == 2'd1) s_duty = int'(wr_data) * 4 + s_duty % 4;
        else if (wr_addr == 2'd2) s_duty = (s_duty / 4) * 4 + int'(wr_data[7:6]);
      end
      m_run = nrun;
      m_pwm = (m_run != 0 && (m_tmr * 4 + m_ph) < m_duty) ? 1 : 0;
    end
  end

  task automatic expect_eq(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      expect_eq("R5 model pwm_out", int'(pwm_out), m_pwm);
      expect_eq("R8 model irq_flag", int'(irq_flag), m_irq);
    end
  end

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_regs(input int p, input int h, input int f);
    wr(0, p); wr(1, h); wr(2, f);
  endtask

  // Measures one full period starting at the next period start
  task automatic measure(output int len, output int hi);
    wr(3, 3);
    while (!irq_flag) @(negedge clk);
    hi = int'(pwm_out); len = 1;
    wr(3, 3);
    while (!irq_flag) begin
      hi += int'(pwm_out); len++;
      @(negedge clk);
    end
  endtask

  function automatic int exp_high(int p, int h, int f);
    int d, l;
    d = h * 4 + (f >> 6);
    l = (p + 1) * 4;
    return (d < l) ? d : l;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    expect_eq("R1 reset pwm_out", int'(pwm_out), 0);
    expect_eq("R1 reset irq_flag", int'(irq_flag), 0);
    rst = 1'b0;
    @(negedge clk);
    expect_eq("R1 idle pwm_out", int'(pwm_out), 0);
  end

  initial begin
    int len, hi;
    @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk); @(negedge clk);

    // R2 R3 R10: full 10-bit mode, duty 0x25B
    program_regs(8'hFF, 8'h96, 8'hC0); wr(3, 1);
    measure(len, hi);
    expect_eq("R2 R10 period FFh length", len, 1024);
    expect_eq("R3 10-bit high time", hi, exp_high(255, 8'h96, 8'hC0));

    // R10: 256-clock mode with 8-bit value 0xA7
    program_regs(8'h3F, 8'h29, 8'hC0);
    measure(len, hi);
    expect_eq("R10 period 3Fh length", len, 256);
    expect_eq("R10 8-bit high time", hi, 167);

    // R4: fraction low bits ignored
    program_regs(8'hFF, 8'h40, 8'h3F);
    measure(len, hi);
    expect_eq("R4 fraction low bits ignored", hi, 256);

    // R3: shortest period with fraction-only duty
    program_regs(0, 0, 8'h80);
    measure(len, hi);
    expect_eq("R2 minimum period", len, 4);
    expect_eq("R3 fraction-only high time", hi, 2);

    // R8: clear lands on the wrap edge, set wins
    wr(3, 3);
    while (!irq_flag) @(negedge clk);
    wr(3, 3);
    @(negedge clk); @(negedge clk);
    wr(3, 3);
    expect_eq("R8 set wins over clear", int'(irq_flag), 1);
    wr(3, 3);
    expect_eq("R8 clear by write-one", int'(irq_flag), 0);
    while (!irq_flag) @(negedge clk);
    repeat (10) @(negedge clk);
    expect_eq("R8 flag sticky", int'(irq_flag), 1);

    // R6: duty beyond period length keeps output high
    program_regs(3, 8'h10, 0);
    measure(len, hi);
    expect_eq("R6 saturated duty high", hi, 16);

    // R9: stop forces low, flag kept
    wr(3, 1);
    while (!irq_flag) @(negedge clk);
    wr(3, 0);
    expect_eq("R9 stop output low", int'(pwm_out), 0);
    expect_eq("R9 stop keeps flag", int'(irq_flag), 1);

    // R7: holding values used from start write
    program_regs(3, 2, 0);
    wr(3, 1);
    expect_eq("R7 first cycle after start", int'(pwm_out), 1);
    measure(len, hi);
    expect_eq("R7 start-up duty", hi, 8);

    // R7: mid-period duty write deferred
    program_regs(8'hFF, 8'h80, 0);
    measure(len, hi);
    expect_eq("R3 half duty", hi, 512);
    wr(1, 0);
    expect_eq("R7 old duty after write", int'(pwm_out), 1);
    repeat (100) @(negedge clk);
    expect_eq("R7 old duty holds mid-period", int'(pwm_out), 1);
    measure(len, hi);
    expect_eq("R6 zero duty low", hi, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule